// File: doc/BRIEF.md
# Data-Valid Serial Readout Register

This block holds one word waiting to be read by an external host: either a fresh conversion result or a newly written configuration value. Both are loaded from the system-clock side. When a word is waiting, the block pulls an active-low data-valid output low.

The host then drives a separate data clock. That clock idles low and is not free-running. On each falling edge of the data clock, the block moves the word out most-significant bit first on a single serial pin. The first falling edge of a readout tells the system side that the word has been taken. That notice passes through a two-flop synchronizer, and the data-valid output then returns high. A configuration value that nobody reads is replaced by the next conversion result.

The system side is a two-state machine. `ST_IDLE` means nothing is waiting and data-valid is high. `ST_READY` means a word is waiting and data-valid is low. It has four transitions:
- **T_LOAD**: a load arrives in `ST_IDLE`, so the word is captured and the machine moves to `ST_READY`.
- **T_OVERWRITE**: a load arrives in `ST_READY` before any readout has started, so the word is replaced and the machine stays in `ST_READY`.
- **T_ACK**: the synchronized acknowledge shows that readout has started and no load is present, so the machine moves to `ST_IDLE`.
- **T_RELOAD**: the acknowledge and a new load coincide, so a new word is captured and the machine stays in `ST_READY`.

The data-clock side keeps a bit counter. The counter is either shifting or done.

Top module: `dvr_readout`

## Requirements
- R1: While reset is asserted and right after it, `dvalid_n` is 1 and `sdout` is 0.
- R2: A conversion load or a configuration load sampled on a `sys_clk` rising edge makes `dvalid_n` 0 after that edge. `sdout` then presents bit W-1 of the loaded word.
- R3: The first `dclk` falling edge after a load clears the flag. `dvalid_n` is still 0 after the second `sys_clk` rising edge that follows that falling edge, and is 1 after the third.
- R4: The word leaves MSB first. Before the first `dclk` falling edge, `sdout` is bit W-1. After the k-th falling edge, for k from 1 to W-1, it is bit W-1-k.
- R5: After the W-th falling edge, `sdout` is 0. It stays 0 through any further `dclk` falling edges until the next load.
- R6: A configuration load makes `cfg_data` the word that is read out.
- R7: A conversion load that arrives while an unread configuration value is waiting replaces it. The readout then yields the conversion data.
- R8: When `conv_load` and `cfg_load` are both 1 in the same cycle, `conv_data` is the word that is loaded.
- R9: With no load, `dvalid_n` stays 1 once it is 1. With no `dclk` edges, a waiting word keeps `dvalid_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; loads are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| conv_load | input | 1 | Single-cycle strobe: a conversion result is ready |
| conv_data | input | W | Conversion result |
| cfg_load | input | 1 | Single-cycle strobe: configuration value updated |
| cfg_data | input | W | Configuration value for readback |
| dclk | input | 1 | Data clock; idles low, output bits change on its falling edge |
| dvalid_n | output | 1 | Active-low flag: a word is waiting |
| sdout | output | 1 | Serial data, MSB first |

## Verification
The checks assume three things about the host. Loads are single-cycle strobes on `sys_clk`. No load arrives between the first `dclk` falling edge of a readout and its W-th falling edge. The data clock idles low and only pulses while a word is waiting or being read.

The bench drives every load half a system cycle away from the sampling edge. Each data-clock pulse starts just after a system falling edge, and no load is issued until a readout has run its full W falling edges.

// File: rtl/dvr_pkg.sv
package dvr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_READY = 1'b1
    } ld_state_e;
endpackage

// File: rtl/dvr_sync2.sv
module dvr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/dvr_load_ctrl.sv
module dvr_load_ctrl
    import dvr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_load,
    input  logic [W-1:0] conv_data,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_data,
    input  logic         ack_s,
    output logic [W-1:0] hold_word,
    output logic         load_tog,
    output logic         dvalid_n
);
    ld_state_e    state_q;
    ld_state_e    state_d;
    logic         flip;
    logic         any_load;
    logic         acked;
    logic [W-1:0] pick;
    logic [W-1:0] word_q;
    logic         tog_q;

    // Conversion data has priority when both strobes coincide.
    assign any_load = conv_load | cfg_load;
    assign pick     = conv_load ? conv_data : cfg_data;
    assign acked    = (ack_s == tog_q);

    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_load) begin        // T_LOAD
                    state_d = ST_READY;
                    flip    = 1'b1;
                end
            end
            ST_READY: begin
                if (acked) begin
                    if (any_load) begin    // T_RELOAD
                        flip = 1'b1;
                    end else begin         // T_ACK
                        state_d = ST_IDLE;
                    end
                end                        // T_OVERWRITE: stay, word replaced
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tog_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            tog_q   <= tog_q ^ flip;
            if (any_load) word_q <= pick;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_READY: dvalid_n = 1'b0;
            default:  dvalid_n = 1'b1;
        endcase
    end

    assign hold_word = word_q;
    assign load_tog  = tog_q;
endmodule

// File: rtl/dvr_shifter.sv
module dvr_shifter #(
    parameter int W = 16
) (
    input  logic         dclk,
    input  logic         rst_n,
    input  logic         load_tog,
    input  logic [W-1:0] word,
    output logic         ack_tog,
    output logic         sdout,
    output logic         done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic [CW-1:0] cnt_q;
    logic          ack_q;
    logic          pending;
    logic [W-1:0]  shifted;

    assign pending = (load_tog != ack_q);

    always_ff @(negedge dclk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            cnt_q <= LAST;
        end else if (pending) begin
            ack_q <= load_tog;
            cnt_q <= CW'(1);
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign shifted = word << cnt_q;

    always_comb begin
        if (pending)            sdout = word[W-1];
        else if (cnt_q != LAST) sdout = shifted[W-1];
        else                    sdout = 1'b0;
    end

    assign ack_tog = ack_q;
    assign done    = (cnt_q == LAST) && !pending;
endmodule

// File: rtl/dvr_readout.sv
module dvr_readout #(
    parameter int W = 16
) (
    input  logic         sys_clk,
    input  logic         rst_n,
    input  logic         conv_load,
    input  logic [W-1:0] conv_data,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_data,
    input  logic         dclk,
    output logic         dvalid_n,
    output logic         sdout
);
    logic [W-1:0] hold_word;
    logic         load_tog;
    logic         ack_tog;
    logic         ack_s;
    logic         sh_done;

    dvr_load_ctrl #(.W(W)) u_load (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .conv_load (conv_load),
        .conv_data (conv_data),
        .cfg_load  (cfg_load),
        .cfg_data  (cfg_data),
        .ack_s     (ack_s),
        .hold_word (hold_word),
        .load_tog  (load_tog),
        .dvalid_n  (dvalid_n)
    );

    dvr_sync2 u_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (ack_tog),
        .q     (ack_s)
    );

    dvr_shifter #(.W(W)) u_shift (
        .dclk     (dclk),
        .rst_n    (rst_n),
        .load_tog (load_tog),
        .word     (hold_word),
        .ack_tog  (ack_tog),
        .sdout    (sdout),
        .done     (sh_done)
    );
endmodule

// File: rtl/dvr_readout_chk.sv
module dvr_readout_chk #(
    parameter int W = 16
) (
    input logic         sys_clk,
    input logic         rst_n,
    input logic         conv_load,
    input logic [W-1:0] conv_data,
    input logic         cfg_load,
    input logic [W-1:0] cfg_data,
    input logic [W-1:0] hold_word,
    input logic         dvalid_n,
    input logic         sdout,
    input logic         done
);
    a_r2_valid_low_after_load: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (conv_load || cfg_load) |=> !dvalid_n);

    a_r8_conv_wins: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (conv_load && cfg_load) |=> (hold_word == $past(conv_data)));

    a_r6_cfg_captured: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cfg_load && !conv_load) |=> (hold_word == $past(cfg_data)));

    a_r9_valid_stays_high: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (dvalid_n && !conv_load && !cfg_load) |=> dvalid_n);

    a_r9_word_held: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!conv_load && !cfg_load) |=> $stable(hold_word));

    a_r5_zero_when_done: assert property (@(posedge sys_clk) disable iff (!rst_n)
        done |-> !sdout);
endmodule

bind dvr_readout dvr_readout_chk #(.W(W)) u_chk (
    .sys_clk   (sys_clk),
    .rst_n     (rst_n),
    .conv_load (conv_load),
    .conv_data (conv_data),
    .cfg_load  (cfg_load),
    .cfg_data  (cfg_data),
    .hold_word (hold_word),
    .dvalid_n  (dvalid_n),
    .sdout     (sdout),
    .done      (sh_done)
);

// File: tb/sim_dvr_readout.sv
module sim_dvr_readout;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_load = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         cfg_load = 1'b0;
    logic [W-1:0] cfg_data = '0;
    logic         dclk = 1'b0;
    logic         dvalid_n;
    logic         sdout;

    int checks = 0;
    int errors = 0;

    dvr_readout #(.W(W)) u0 (
        .sys_clk(clk), .rst_n(rst_n), .conv_load(conv_load), .conv_data(conv_data),
        .cfg_load(cfg_load), .cfg_data(cfg_data), .dclk(dclk),
        .dvalid_n(dvalid_n), .sdout(sdout)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive strobes, then check R2 at the next system falling edge.
    task automatic do_load(input logic cv, input logic [W-1:0] cd,
                           input logic cf, input logic [W-1:0] fd,
                           input logic [W-1:0] expw);
        @(negedge clk);
        conv_load = cv; conv_data = cd; cfg_load = cf; cfg_data = fd;
        @(negedge clk);
        conv_load = 1'b0; cfg_load = 1'b0;
        chk("R2 dvalid_n low after load", 32'(dvalid_n), 32'd0);
        chk("R2 msb presented", 32'(sdout), 32'(expw[W-1]));
    endtask

    task automatic dclk_pulse();
        @(negedge clk); #2 dclk = 1'b1;
        @(negedge clk); #2 dclk = 1'b0;
        #1;
    endtask

    task automatic read_word(input logic [W-1:0] expw, input string tag);
        chk({tag, " R4 bit msb"}, 32'(sdout), 32'(expw[W-1]));
        for (int k = 1; k <= W; k++) begin
            dclk_pulse();
            if (k < W) chk({tag, " R4 bit"}, 32'(sdout), 32'(expw[W-1-k]));
            else       chk({tag, " R5 zero after last bit"}, 32'(sdout), 32'd0);
            if (k == 1) begin
                @(negedge clk); @(negedge clk);
                chk({tag, " R3 dvalid_n low two edges after fall"}, 32'(dvalid_n), 32'd0);
                @(negedge clk);
                chk({tag, " R3 dvalid_n high third edge"}, 32'(dvalid_n), 32'd1);
            end
        end
        dclk_pulse();
        chk({tag, " R5 zero on extra edge"}, 32'(sdout), 32'd0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 dvalid_n in reset", 32'(dvalid_n), 32'd1);
        chk("R1 sdout in reset", 32'(sdout), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dvalid_n after reset", 32'(dvalid_n), 32'd1);
        chk("R1 sdout after reset", 32'(sdout), 32'd0);
    endtask

    task automatic t_conv_read();
        do_load(1'b1, 16'hA5C3, 1'b0, 16'h0000, 16'hA5C3);
        read_word(16'hA5C3, "conv");
    endtask

    task automatic t_cfg_read();
        do_load(1'b0, 16'hFFFF, 1'b1, 16'h5B19, 16'h5B19);
        read_word(16'h5B19, "R6 cfg");
    endtask

    task automatic t_overwrite();
        do_load(1'b0, 16'h0000, 1'b1, 16'hF00F, 16'hF00F);
        repeat (4) @(negedge clk);
        do_load(1'b1, 16'h1234, 1'b0, 16'h0000, 16'h1234);
        read_word(16'h1234, "R7 overwrite");
    endtask

    task automatic t_simul();
        do_load(1'b1, 16'h6E81, 1'b1, 16'hFFFF, 16'h6E81);
        read_word(16'h6E81, "R8 simultaneous");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 8; i++) @(negedge clk);
        chk("R9 dvalid_n stays high", 32'(dvalid_n), 32'd1);
        chk("R5 sdout stays zero idle", 32'(sdout), 32'd0);
        do_load(1'b1, 16'h8001, 1'b0, 16'h0000, 16'h8001);
        for (int i = 0; i < 12; i++) @(negedge clk);
        chk("R9 dvalid_n stays low without dclk", 32'(dvalid_n), 32'd0);
        read_word(16'h8001, "R9 late read");
    endtask

    initial begin
        t_reset();
        t_conv_read();
        t_cfg_read();
        t_overwrite();
        t_simul();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule